// File: doc/BRIEF.md
# Dual Alarm Interrupt Output Controller

This block sits between two alarm sources of a timekeeping device (a watchdog countdown and a time-of-day match) and two interrupt pins, A and B. Each alarm raises a sticky flag when its event input pulses. The flag clears when software touches that alarm's own registers, which reaches the block as a one-cycle clear strobe. An 8-bit command register, written and read over a simple bus, controls the outputs. It sets which alarm drives which pin, masks each alarm, chooses level or stretched-pulse signalling, and sets the active level of pin B. Pin A is always active-low.

Each pin is modelled as a value plus an output enable. The enable is high only while an interrupt is being signalled, so the pin can be built as open-drain or push-pull outside the block. In pulse mode a flag lives only as long as its pulse. The pulse is timed by a 1 kHz enable (`ms_tick`) and lasts at least `PULSE_TICKS` whole tick periods. The top bit of the command register is only stored, and it is exported inverted as a freeze request for the clock-update logic.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset, `cmd_rdata` reads 8'hCC: update-enable=1, swap=1, B level=0, level mode, both alarms masked, both flags 0. Both pins have `oe`=0 and `val`=1, and `freeze_updates`=0.
- R2: Command bit 6 (swap) routes the alarms. At 1, pin A carries the time-of-day alarm and pin B the watchdog. At 0, pin A carries the watchdog and pin B the time-of-day alarm.
- R3: Bit 3 masks the watchdog and bit 2 masks the time-of-day alarm. A mask value of 1 keeps that alarm off its pin but does not stop its flag from setting.
- R4: An asserted pin A drives `val`=0. An asserted pin B drives `val` equal to command bit 5. An idle pin has `oe`=0 and `val` at the inverse of its active level.
- R5: The watchdog flag reads at bit 1 and the time-of-day flag at bit 0. An event sets the flag on the next edge. A clear strobe resets it on the next edge, and the clear wins when both arrive in the same cycle.
- R6: In level mode (bit 4 = 0), a set flag and its asserted pin stay set, across any number of ticks, until the clear strobe.
- R7: In pulse mode (bit 4 = 1), a flag stays set through `PULSE_TICKS` ticks after its event and drops on the next tick. The pin follows the flag.
- R8: Command writes store bits 7..2 only. Bits 1 and 0 of the write data are ignored, and the flags are neither set nor cleared by a write.
- R9: Command bit 7 is stored as written, and `freeze_updates` equals its inverse.
- R10: The pin outputs are registered. A pin changes one clock after the flag or command change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_event | input | 1 | Watchdog alarm event, one-cycle pulse |
| tod_event | input | 1 | Time-of-day alarm event, one-cycle pulse |
| wd_clr | input | 1 | Watchdog register access strobe, clears watchdog flag |
| tod_clr | input | 1 | Time-of-day alarm register access strobe, clears its flag |
| ms_tick | input | 1 | 1 kHz single-cycle enable for pulse timing |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command register write data |
| cmd_rdata | output | 8 | Command register readback with flags in bits 1..0 |
| irq_a_val | output | 1 | Pin A value (active-low) |
| irq_a_oe | output | 1 | Pin A output enable, high while asserted |
| irq_b_val | output | 1 | Pin B value (active level from bit 5) |
| irq_b_oe | output | 1 | Pin B output enable, high while asserted |
| freeze_updates | output | 1 | High while command bit 7 is 0 |

## Verification
Some properties are checked on every cycle: pin A never drives high while enabled, and pin B's driven value always matches the polarity bit of the cycle before. A pin is enabled only when its routed alarm was flagged and unmasked one cycle earlier. Flags set on events, drop on clears, never appear without an event, and hold in level mode. Other behaviour can only be shown by the directed scenarios: the pulse length counted in ticks, with release on exactly the tick after `PULSE_TICKS`, the reversal of routing when the swap bit changes, and the rule that write data bits 1..0 leave the flags alone.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned NUM_ALARM = 2;
  localparam int unsigned IDX_TOD   = 0;
  localparam int unsigned IDX_WD    = 1;

  typedef struct packed {
    logic upd_en;
    logic swap;
    logic b_level;
    logic pulse_mode;
    logic wd_mask;
    logic tod_mask;
  } cmd_t;

  localparam cmd_t CMD_RESET = '{upd_en: 1'b1, swap: 1'b1, b_level: 1'b0,
                                 pulse_mode: 1'b0, wd_mask: 1'b1, tod_mask: 1'b1};
endpackage

// File: rtl/alarm_flag_chan.sv
module alarm_flag_chan #(
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic event_i,
  input  logic clr_i,
  input  logic tick_i,
  input  logic pulse_mode_i,
  output logic flag_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_TICKS);

  logic [CNT_W-1:0] remain_q;
  logic             flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= 1'b0;
      remain_q <= '0;
    end else if (clr_i) begin
      flag_q   <= 1'b0;
      remain_q <= '0;
    end else if (event_i) begin
      flag_q   <= 1'b1;
      remain_q <= CNT_LOAD;
    end else if (pulse_mode_i && flag_q && tick_i) begin
      if (remain_q == '0) flag_q <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic active_lvl_i,
  output logic val_o,
  output logic oe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val_o <= 1'b1;
      oe_o  <= 1'b0;
    end else begin
      oe_o  <= req_i;
      val_o <= req_i ? active_lvl_i : ~active_lvl_i;
    end
  end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 3,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wd_event,
  input  logic              tod_event,
  input  logic              wd_clr,
  input  logic              tod_clr,
  input  logic              ms_tick,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] cmd_rdata,
  output logic              irq_a_val,
  output logic              irq_a_oe,
  output logic              irq_b_val,
  output logic              irq_b_oe,
  output logic              freeze_updates
);
  localparam int unsigned CTRL_BITS = $bits(cmd_t);

  cmd_t                 cmd_q;
  logic [NUM_ALARM-1:0] ev_vec, clr_vec, flag_vec, mask_vec, req_vec;
  logic                 req_a, req_b;

  always_ff @(posedge clk) begin
    if (rst)         cmd_q <= CMD_RESET;
    else if (cmd_we) cmd_q <= cmd_t'(cmd_wdata[DATA_W-1 -: CTRL_BITS]);
  end

  assign ev_vec[IDX_TOD]   = tod_event;
  assign ev_vec[IDX_WD]    = wd_event;
  assign clr_vec[IDX_TOD]  = tod_clr;
  assign clr_vec[IDX_WD]   = wd_clr;
  assign mask_vec[IDX_TOD] = cmd_q.tod_mask;
  assign mask_vec[IDX_WD]  = cmd_q.wd_mask;

  for (genvar g = 0; g < NUM_ALARM; g++) begin : g_chan
    alarm_flag_chan #(.PULSE_TICKS(PULSE_TICKS)) u_chan (
      .clk          (clk),
      .rst          (rst),
      .event_i      (ev_vec[g]),
      .clr_i        (clr_vec[g]),
      .tick_i       (ms_tick),
      .pulse_mode_i (cmd_q.pulse_mode),
      .flag_o       (flag_vec[g])
    );
    assign req_vec[g] = flag_vec[g] & ~mask_vec[g];
  end

  assign req_a = cmd_q.swap ? req_vec[IDX_TOD] : req_vec[IDX_WD];
  assign req_b = cmd_q.swap ? req_vec[IDX_WD]  : req_vec[IDX_TOD];

  irq_pin_drv u_pin_a (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_a),
    .active_lvl_i (1'b0),
    .val_o        (irq_a_val),
    .oe_o         (irq_a_oe)
  );

  irq_pin_drv u_pin_b (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_b),
    .active_lvl_i (cmd_q.b_level),
    .val_o        (irq_b_val),
    .oe_o         (irq_b_oe)
  );

  assign cmd_rdata      = {cmd_q, flag_vec[IDX_WD], flag_vec[IDX_TOD]};
  assign freeze_updates = ~cmd_q.upd_en;
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wd_event,
  input logic       tod_event,
  input logic       wd_clr,
  input logic       tod_clr,
  input logic [7:0] cmd_rdata,
  input logic       irq_a_val,
  input logic       irq_a_oe,
  input logic       irq_b_val,
  input logic       irq_b_oe,
  input logic       freeze_updates
);
  AST_A_ACTIVE_LOW: assert property (@(posedge clk) disable iff (rst)
    irq_a_oe |-> !irq_a_val);  // R4
  AST_B_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_b_oe |-> (irq_b_val == $past(cmd_rdata[5])));  // R4
  AST_A_ROUTE: assert property (@(posedge clk) disable iff (rst)
    irq_a_oe |-> $past(cmd_rdata[6] ? (cmd_rdata[0] && !cmd_rdata[2])
                                    : (cmd_rdata[1] && !cmd_rdata[3])));  // R2
  AST_B_ROUTE: assert property (@(posedge clk) disable iff (rst)
    irq_b_oe |-> $past(cmd_rdata[6] ? (cmd_rdata[1] && !cmd_rdata[3])
                                    : (cmd_rdata[0] && !cmd_rdata[2])));  // R3
  AST_WD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wd_clr |=> !cmd_rdata[1]);  // R5
  AST_TOD_SET: assert property (@(posedge clk) disable iff (rst)
    (tod_event && !tod_clr) |=> cmd_rdata[0]);  // R5
  AST_WD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!cmd_rdata[1] && !wd_event) |=> !cmd_rdata[1]);  // R8
  AST_TOD_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdata[0] && !cmd_rdata[4] && !tod_clr) |=> cmd_rdata[0]);  // R6
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    freeze_updates == !cmd_rdata[7]);  // R9
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .wd_event       (wd_event),
  .tod_event      (tod_event),
  .wd_clr         (wd_clr),
  .tod_clr        (tod_clr),
  .cmd_rdata      (cmd_rdata),
  .irq_a_val      (irq_a_val),
  .irq_a_oe       (irq_a_oe),
  .irq_b_val      (irq_b_val),
  .irq_b_oe       (irq_b_oe),
  .freeze_updates (freeze_updates)
);

// File: tb/alarm_irq_ctrl_bench.sv
module alarm_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wd_event = 0, tod_event = 0, wd_clr = 0, tod_clr = 0, ms_tick = 0;
  logic       cmd_we = 0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] cmd_rdata;
  logic       irq_a_val, irq_a_oe, irq_b_val, irq_b_oe, freeze_updates;
  int         nchecks = 0;
  int         nfail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_irq_ctrl #(.PULSE_TICKS(TICKS)) u_alarm_irq_ctrl (
    .clk(clk), .rst(rst), .wd_event(wd_event), .tod_event(tod_event),
    .wd_clr(wd_clr), .tod_clr(tod_clr), .ms_tick(ms_tick), .cmd_we(cmd_we),
    .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .irq_a_val(irq_a_val),
    .irq_a_oe(irq_a_oe), .irq_b_val(irq_b_val), .irq_b_oe(irq_b_oe),
    .freeze_updates(freeze_updates));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_cmd(logic [7:0] d);
    cmd_we = 1; cmd_wdata = d; step(); cmd_we = 0;
  endtask

  task automatic fire(bit wd);
    if (wd) wd_event = 1; else tod_event = 1;
    step(); wd_event = 0; tod_event = 0;
  endtask

  task automatic clear_all();
    wd_clr = 1; tod_clr = 1; step(); wd_clr = 0; tod_clr = 0; step();
  endtask

  task automatic t_reset();
    check("R1", "rdata", cmd_rdata, 8'hCC);
    check("R1", "pins", {irq_a_oe, irq_a_val, irq_b_oe, irq_b_val}, 8'b0101);
    check("R1", "freeze", freeze_updates, 0);
  endtask

  task automatic t_routing();
    wr_cmd(8'b1100_0000);
    fire(1);
    check("R5", "wd flag set", cmd_rdata[1], 1);
    check("R10", "b not yet", irq_b_oe, 0);
    step();
    check("R2", "swap1 wd->B", {irq_a_oe, irq_b_oe, irq_b_val}, 3'b010);
    clear_all();
    check("R5", "flags cleared", cmd_rdata[1:0], 2'b00);
    fire(0); step();
    check("R2", "swap1 tod->A", {irq_a_oe, irq_a_val, irq_b_oe}, 3'b100);
    clear_all();
    wr_cmd(8'b1000_0000);
    fire(1); step();
    check("R2", "swap0 wd->A", {irq_a_oe, irq_a_val, irq_b_oe}, 3'b100);
    clear_all();
    fire(0); step();
    check("R2", "swap0 tod->B", {irq_a_oe, irq_b_oe}, 2'b01);
    clear_all();
  endtask

  task automatic t_mask();
    wr_cmd(8'b1100_1000);
    fire(1); step();
    check("R3", "wd masked flag", cmd_rdata[1], 1);
    check("R3", "wd masked pin", irq_b_oe, 0);
    clear_all();
    wr_cmd(8'b1100_0100);
    fire(0); step();
    check("R3", "tod masked flag", cmd_rdata[0], 1);
    check("R3", "tod masked pin", irq_a_oe, 0);
    wr_cmd(8'b1100_0000); step();
    check("R3", "tod unmasked pin", irq_a_oe, 1);
    clear_all();
  endtask

  task automatic t_polarity();
    wr_cmd(8'b1110_0000); step();
    check("R4", "b idle val", {irq_b_oe, irq_b_val}, 2'b00);
    fire(1); step();
    check("R4", "b high active", {irq_b_oe, irq_b_val}, 2'b11);
    clear_all();
    check("R4", "b release", {irq_b_oe, irq_b_val}, 2'b00);
  endtask

  task automatic t_level();
    wr_cmd(8'b1100_0000);
    fire(0);
    for (int i = 0; i < 20; i++) begin
      ms_tick = 1; step(); ms_tick = 0; step();
    end
    check("R6", "level hold flag", cmd_rdata[0], 1);
    check("R6", "level hold pin", irq_a_oe, 1);
    tod_event = 1; tod_clr = 1; step(); tod_event = 0; tod_clr = 0;
    check("R5", "clear wins", cmd_rdata[0], 0);
    step();
    check("R6", "pin released", irq_a_oe, 0);
  endtask

  task automatic t_pulse();
    wr_cmd(8'b1101_0000);
    fire(1);
    for (int i = 0; i < TICKS; i++) begin
      ms_tick = 1; step(); ms_tick = 0; step();
      check("R7", "pulse flag alive", cmd_rdata[1], 1);
      check("R7", "pulse pin alive", irq_b_oe, 1);
    end
    ms_tick = 1; step(); ms_tick = 0;
    check("R7", "pulse flag drop", cmd_rdata[1], 0);
    step();
    check("R7", "pulse pin drop", irq_b_oe, 0);
  endtask

  task automatic t_write_ignore();
    wr_cmd(8'hFF);
    check("R8", "write ff", cmd_rdata, 8'hFC);
    wr_cmd(8'b1100_1100);
    fire(0);
    wr_cmd(8'b1100_1100);
    check("R8", "write keeps flag", cmd_rdata, 8'hCD);
    clear_all();
  endtask

  task automatic t_freeze();
    wr_cmd(8'h4C);
    check("R9", "freeze on", {freeze_updates, cmd_rdata[7]}, 2'b10);
    wr_cmd(8'hCC);
    check("R9", "freeze off", {freeze_updates, cmd_rdata[7]}, 2'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchecks++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    t_reset();
    t_routing();
    t_mask();
    t_polarity();
    t_level();
    t_pulse();
    t_write_ignore();
    t_freeze();
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end
endmodule